// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a non-blocking time-division switch for eight serial streams of 32 eight-bit channels per frame. One clock cycle is one channel time: in each cycle the block receives the byte of the current channel on all eight input streams at once. It delivers, one cycle later, the byte for the same channel on all eight output streams. The bit-level serializer and the tri-state pads lie outside the block, so every output stream is a parallel byte plus an enable flag and a strobe flag.

A data memory keeps two frames of input bytes, one being written and one holding the previous frame. For each output stream and channel, a connection entry either names a source stream and source channel whose captured byte is copied, or supplies a fixed message byte. The same entry carries an output enable, a strobe bit and a choice between variable and constant throughput delay. A small register port writes connection entries and a control register. Writes go into a pending copy and become active only at the next frame boundary.

Sequencing is a two-state machine. `ST_IDLE` (hunting) is entered at reset: no slot is processed and all outputs stay dark. The transition `IDLE->RUN` is taken on the first frame pulse. `ST_RUN` (locked) then advances the slot counter every cycle. The transition `RUN->RUN` is taken every cycle; a frame pulse in `ST_RUN` re-aligns the counter to slot 0.

Top module: `tsi_switch`

## Requirements
- R1: After reset the block is in the hunting state until the first `frame_sync` pulse; while hunting, `tx_oe`, `tx_strobe` and `tx_data` are all zero and no input byte is captured.
- R2: A cycle with `frame_sync` high is slot 0. Each later cycle is the next slot, and after slot 31 the counter wraps to slot 0. The wrap is a frame boundary exactly as a pulse is. `tx_chan` shows the slot whose bytes are on the outputs.
- R3: For a switched channel, the low connection word holds the source stream in bits 7-5 and the source channel in bits 4-0 (most significant bit first); the output byte is the byte captured from that stream and channel.
- R4: When bit 2 of the high connection word is 1, the whole low word is sent unchanged as a message byte.
- R5: When bit 6 of the active control register is 1, every channel behaves as a message channel regardless of its own bit 2.
- R6: Bit 0 of the high connection word enables the output of that stream in that slot; a disabled output shows `tx_oe` low and `tx_data` zero.
- R7: Bit 1 of the high connection word appears on `tx_strobe` for that stream in that slot, independent of the enable.
- R8: When bit 6 of the high word is 0 (variable delay), a source channel numbered lower than the output slot is read from the current frame; a source channel equal to or higher than the output slot is read from the previous frame.
- R9: When bit 6 of the high word is 1 (constant delay), the source byte is always taken from the previous frame.
- R10: While `out_allow` is low, every `tx_oe` bit is low and every `tx_data` byte is zero. While it is high, the per-channel enable bits decide.
- R11: High-word bits 7 and 5-3, and every control register bit except bit 6, have no effect on any output.
- R12: A connection or control write takes effect from the next frame boundary; slots of the current frame, including a slot-0 cycle that carries the write, use the previously active values.
- R13: The output for a slot is registered one cycle after its connection entry is read. Bytes driven with slot n show up on the outputs in the following cycle, with `tx_chan` = n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per channel time |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High in the cycle that is slot 0 of a frame |
| out_allow | input | 1 | Global output permission; low disables all outputs |
| rx_data | input | 64 | Input bytes of the current slot, stream s in bits 8s+7..8s |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 low connection word, 1 high connection word, 2 control, 3 none |
| reg_addr | input | 8 | Connection entry: output stream in bits 7-5, output channel in bits 4-0 |
| reg_wdata | input | 8 | Write data |
| tx_data | output | 64 | Output bytes, stream s in bits 8s+7..8s |
| tx_oe | output | 8 | Per-stream output enable for the current output slot |
| tx_strobe | output | 8 | Per-stream strobe bit for the current output slot |
| tx_chan | output | 5 | Slot number of the bytes on the outputs |

## Verification
Some properties hold on every cycle and are watched continuously: the global disable forcing every enable low, a disabled stream showing a zero byte, the slot number restarting at zero after a pulse and otherwise stepping by one with wrap, and silence while hunting. The routing itself cannot be judged from one cycle. That covers which byte a channel carries, which frame half a variable-delay read picks, message forcing by the control bit, the ignored bits, and the deferral of writes to the frame boundary. The bench shows these by sweeping every stream and channel of several connection maps, with frames started both by pulses and by counter wrap, and with one shortened frame. Its model tracks pending and active connection state and both frame halves.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tsi_state_e;

    typedef enum logic [1:0] {
        SEL_CONN_LO = 2'd0,
        SEL_CONN_HI = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    // bit positions inside the 8-bit high connection word and control word
    localparam int HI_OE_BIT     = 0;
    localparam int HI_STB_BIT    = 1;
    localparam int HI_MSG_BIT    = 2;
    localparam int HI_CDEL_BIT   = 6;
    localparam int CTL_FORCE_BIT = 6;

    // only the meaningful high-word bits are stored
    typedef struct packed {
        logic cdel;
        logic msg;
        logic stb;
        logic oe;
    } hi_bits_t;

    localparam int HIW = $bits(hi_bits_t);

    function automatic hi_bits_t pick_hi(input logic [7:0] w);
        hi_bits_t h;
        h.cdel = w[HI_CDEL_BIT];
        h.msg  = w[HI_MSG_BIT];
        h.stb  = w[HI_STB_BIT];
        h.oe   = w[HI_OE_BIT];
        return h;
    endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
    import tsi_pkg::*;
#(
    parameter int NCH = 32,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    output logic          run,
    output logic [CW-1:0] slot,
    output logic          boundary,
    output logic          half
);

    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    tsi_state_e    st_q, st_d;
    logic [CW-1:0] nxt_q;
    logic          half_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (frame_sync) st_d = ST_RUN;
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign run      = frame_sync || (st_q == ST_RUN);
    assign slot     = frame_sync ? '0 : nxt_q;
    assign boundary = run && (slot == '0);
    assign half     = boundary ? ~half_q : half_q;

    // slot counter and frame half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_q  <= '0;
            half_q <= 1'b0;
        end else if (run) begin
            nxt_q  <= (slot == LAST) ? '0 : slot + 1'b1;
            half_q <= half;
        end
    end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int NSTR = 8,
    parameter int NCH  = 32,
    parameter int BW   = 8,
    localparam int SW   = $clog2(NSTR),
    localparam int CW   = $clog2(NCH),
    localparam int AW   = SW + CW,
    localparam int NENT = NSTR * NCH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [1:0]         sel,
    input  logic [AW-1:0]      addr,
    input  logic [BW-1:0]      wdata,
    input  logic               boundary,
    input  logic [CW-1:0]      slot,
    output logic [NSTR*BW-1:0] lo_o,
    output logic [NSTR*HIW-1:0] hi_o,
    output logic               force_o
);

    logic [BW-1:0] pend_lo [NENT];
    logic [BW-1:0] act_lo  [NENT];
    hi_bits_t      pend_hi [NENT];
    hi_bits_t      act_hi  [NENT];
    logic          pend_force, act_force;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                pend_lo[i] <= '0;
                act_lo[i]  <= '0;
                pend_hi[i] <= '0;
                act_hi[i]  <= '0;
            end
            pend_force <= 1'b0;
            act_force  <= 1'b0;
        end else begin
            if (wr) begin
                unique case (reg_sel_e'(sel))
                    SEL_CONN_LO: pend_lo[addr] <= wdata;
                    SEL_CONN_HI: pend_hi[addr] <= pick_hi(wdata);
                    SEL_CTRL:    pend_force    <= wdata[CTL_FORCE_BIT];
                    default: ;
                endcase
            end
            if (boundary) begin
                for (int i = 0; i < NENT; i++) begin
                    act_lo[i] <= pend_lo[i];
                    act_hi[i] <= pend_hi[i];
                end
                act_force <= pend_force;
            end
        end
    end

    // the boundary slot already sees the values that become active there
    assign force_o = boundary ? pend_force : act_force;

    for (genvar s = 0; s < NSTR; s++) begin : g_rd
        localparam logic [SW-1:0] SI = SW'(s);
        logic [AW-1:0] idx;
        assign idx = {SI, slot};
        assign lo_o[s*BW +: BW]   = boundary ? pend_lo[idx] : act_lo[idx];
        assign hi_o[s*HIW +: HIW] = boundary ? pend_hi[idx] : act_hi[idx];
    end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
    parameter int NSTR = 8,
    parameter int NCH  = 32,
    parameter int BW   = 8,
    localparam int SW  = $clog2(NSTR),
    localparam int CW  = $clog2(NCH),
    localparam int AW  = SW + CW
) (
    input  logic               clk,
    input  logic               we,
    input  logic               half,
    input  logic [CW-1:0]      slot,
    input  logic [NSTR*BW-1:0] wdata,
    input  logic [NSTR-1:0]    rd_half,
    input  logic [NSTR*AW-1:0] rd_idx,
    output logic [NSTR*BW-1:0] rd_data
);

    localparam int DEPTH = 2 * NSTR * NCH;

    logic [BW-1:0] mem [DEPTH];

    // every stream writes its byte of the current slot into the live half
    always_ff @(posedge clk) begin
        if (we) begin
            for (int s = 0; s < NSTR; s++) begin
                mem[{half, SW'(s), slot}] <= wdata[s*BW +: BW];
            end
        end
    end

    for (genvar s = 0; s < NSTR; s++) begin : g_rd
        assign rd_data[s*BW +: BW] = mem[{rd_half[s], rd_idx[s*AW +: AW]}];
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NSTR = 8,
    parameter int NCH  = 32,
    parameter int BW   = 8,
    localparam int SW  = $clog2(NSTR),
    localparam int CW  = $clog2(NCH),
    localparam int AW  = SW + CW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_sync,
    input  logic               out_allow,
    input  logic [NSTR*BW-1:0] rx_data,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [AW-1:0]      reg_addr,
    input  logic [BW-1:0]      reg_wdata,
    output logic [NSTR*BW-1:0] tx_data,
    output logic [NSTR-1:0]    tx_oe,
    output logic [NSTR-1:0]    tx_strobe,
    output logic [CW-1:0]      tx_chan
);

    logic                slot_run, boundary, half;
    logic [CW-1:0]       slot;
    logic [NSTR*BW-1:0]  cm_lo;
    logic [NSTR*HIW-1:0] cm_hi;
    logic                force_msg;
    logic [NSTR-1:0]     rd_half;
    logic [NSTR*AW-1:0]  rd_idx;
    logic [NSTR*BW-1:0]  rd_data;
    logic [NSTR*BW-1:0]  nxt_dat, dat_q;
    logic [NSTR-1:0]     nxt_oe, nxt_stb, oe_q, stb_q;
    logic [CW-1:0]       chan_q;

    tsi_slot_timer #(.NCH(NCH)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .run        (slot_run),
        .slot       (slot),
        .boundary   (boundary),
        .half       (half)
    );

    tsi_conn_mem #(.NSTR(NSTR), .NCH(NCH), .BW(BW)) u_conn (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .sel      (reg_sel),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .boundary (boundary),
        .slot     (slot),
        .lo_o     (cm_lo),
        .hi_o     (cm_hi),
        .force_o  (force_msg)
    );

    tsi_data_mem #(.NSTR(NSTR), .NCH(NCH), .BW(BW)) u_data (
        .clk     (clk),
        .we      (slot_run),
        .half    (half),
        .slot    (slot),
        .wdata   (rx_data),
        .rd_half (rd_half),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    for (genvar s = 0; s < NSTR; s++) begin : g_path
        logic [BW-1:0] lo;
        hi_bits_t      hi;
        logic          msg, use_cur;

        assign lo      = cm_lo[s*BW +: BW];
        assign hi      = hi_bits_t'(cm_hi[s*HIW +: HIW]);
        assign msg     = hi.msg | force_msg;
        // variable delay: a source slot already passed in this frame is live
        assign use_cur = !hi.cdel && (lo[CW-1:0] < slot);

        assign rd_half[s]          = use_cur ? half : ~half;
        assign rd_idx[s*AW +: AW]  = lo[AW-1:0];
        assign nxt_dat[s*BW +: BW] = msg ? lo : rd_data[s*BW +: BW];
        assign nxt_oe[s]           = hi.oe;
        assign nxt_stb[s]          = hi.stb;

        assign tx_data[s*BW +: BW] = tx_oe[s] ? dat_q[s*BW +: BW] : '0;
    end

    // output process: one slot of latency after the connection read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q  <= '0;
            oe_q   <= '0;
            stb_q  <= '0;
            chan_q <= '0;
        end else if (slot_run) begin
            dat_q  <= nxt_dat;
            oe_q   <= nxt_oe;
            stb_q  <= nxt_stb;
            chan_q <= slot;
        end else begin
            dat_q <= '0;
            oe_q  <= '0;
            stb_q <= '0;
        end
    end

    assign tx_oe     = oe_q & {NSTR{out_allow}};
    assign tx_strobe = stb_q;
    assign tx_chan   = chan_q;

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int NSTR = 8,
    parameter int NCH  = 32,
    parameter int BW   = 8,
    localparam int CW  = $clog2(NCH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_sync,
    input logic               out_allow,
    input logic               run,
    input logic [NSTR*BW-1:0] tx_data,
    input logic [NSTR-1:0]    tx_oe,
    input logic [NSTR-1:0]    tx_strobe,
    input logic [CW-1:0]      tx_chan
);

    localparam logic [CW-1:0] ONE = CW'(1);

    p_global_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_allow |-> (tx_oe == '0));

    p_pulse_slot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (tx_chan == '0));

    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_sync) |=> (tx_chan == $past(tx_chan) + ONE));

    p_hunt_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (tx_oe == '0 && tx_strobe == '0));

    for (genvar s = 0; s < NSTR; s++) begin : g_zero
        p_off_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_oe[s] |-> (tx_data[s*BW +: BW] == '0));
    end

endmodule

bind tsi_switch tsi_switch_chk #(.NSTR(NSTR), .NCH(NCH), .BW(BW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .out_allow  (out_allow),
    .run        (slot_run),
    .tx_data    (tx_data),
    .tx_oe      (tx_oe),
    .tx_strobe  (tx_strobe),
    .tx_chan    (tx_chan)
);

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;

    localparam int NSTR = 8;
    localparam int NCH  = 32;
    localparam int NENT = NSTR * NCH;
    localparam int QMAX = 1200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        out_allow = 1'b1;
    logic [63:0] rx_data = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [63:0] tx_data;
    logic [7:0]  tx_oe, tx_strobe;
    logic [4:0]  tx_chan;

    always #2 clk = ~clk;

    tsi_switch u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .out_allow(out_allow),
        .rx_data(rx_data), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tx_data(tx_data), .tx_oe(tx_oe),
        .tx_strobe(tx_strobe), .tx_chan(tx_chan)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // bench model of the requirements
    logic [7:0] m_plo [NENT], m_phi [NENT], m_alo [NENT], m_ahi [NENT];
    logic [7:0] m_pctl = 8'h00, m_actl = 8'h00;
    logic [7:0] m_dm [2][NENT];
    bit         m_dv [2][NENT];
    bit         m_half = 0, m_run = 0;
    int         m_next = 0, fr = 0;

    logic [7:0] e_dat [NSTR];
    bit         e_oe [NSTR], e_stb [NSTR], e_dchk [NSTR];
    string      e_tag [NSTR];
    logic [4:0] e_chan = '0;
    bit         e_have = 0;

    logic [1:0] wq_sel  [QMAX];
    logic [7:0] wq_addr [QMAX], wq_dat [QMAX];
    int         wq_n = 0, wq_rd = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int f, input int s, input int c);
        return 8'(f * 41 + s * 97 + c * 13 + 7);
    endfunction

    task automatic push(input logic [1:0] sel, input logic [7:0] a, input logic [7:0] d);
        wq_sel[wq_n] = sel; wq_addr[wq_n] = a; wq_dat[wq_n] = d;
        wq_n++;
    endtask

    // one slot: check the previous slot's outputs, then drive this slot
    task automatic slot(input bit pulse, input bit ok);
        int cur;
        bit running;
        @(negedge clk);
        if (e_have) begin
            chk("R2 R13 chan", 32'(tx_chan), 32'(e_chan));
            for (int s = 0; s < NSTR; s++) begin
                chk({e_tag[s], " oe"}, 32'(tx_oe[s]), 32'(e_oe[s]));
                chk("R7 strobe", 32'(tx_strobe[s]), 32'(e_stb[s]));
                if (e_dchk[s]) chk({e_tag[s], " data"}, 32'(tx_data[s*8 +: 8]), 32'(e_dat[s]));
            end
        end
        out_allow = ok;
        running = pulse || m_run;
        cur = pulse ? 0 : m_next;
        if (running && cur == 0) begin
            for (int i = 0; i < NENT; i++) begin
                m_alo[i] = m_plo[i];
                m_ahi[i] = m_phi[i];
            end
            m_actl = m_pctl;
            m_half = ~m_half;
            fr++;
        end
        for (int s = 0; s < NSTR; s++) begin
            if (!running) begin
                e_oe[s] = 0; e_stb[s] = 0; e_dat[s] = 8'h00; e_dchk[s] = 1; e_tag[s] = "R1";
            end else begin
                int idx, sidx;
                logic [7:0] lo, hi;
                bit msg, use_cur, h;
                idx = s * NCH + cur;
                lo = m_alo[idx];
                hi = m_ahi[idx];
                msg = hi[2] | m_actl[6];
                e_oe[s] = hi[0] & ok;
                e_stb[s] = hi[1];
                if (msg) begin
                    e_dat[s] = lo; e_dchk[s] = 1;
                end else begin
                    use_cur = !hi[6] && (int'(lo[4:0]) < cur);
                    h = use_cur ? m_half : ~m_half;
                    sidx = int'(lo[7:5]) * NCH + int'(lo[4:0]);
                    e_dat[s] = m_dm[h][sidx];
                    e_dchk[s] = m_dv[h][sidx];
                end
                if (!e_oe[s]) begin
                    e_dat[s] = 8'h00; e_dchk[s] = 1;
                end
                if (!ok)             e_tag[s] = "R10";
                else if (!hi[0])     e_tag[s] = "R6";
                else if (m_actl[6])  e_tag[s] = "R5";
                else if (hi[2])      e_tag[s] = "R4";
                else if (hi[6])      e_tag[s] = "R3 R9";
                else                 e_tag[s] = "R3 R8";
                if ((hi & 8'hB8) != 0 || (m_actl & 8'hBF) != 0) e_tag[s] = {e_tag[s], " R11"};
                if (m_plo[idx] !== lo || m_phi[idx] !== hi || m_pctl[6] !== m_actl[6])
                    e_tag[s] = {e_tag[s], " R12"};
            end
        end
        for (int s = 0; s < NSTR; s++) begin
            rx_data[s*8 +: 8] = pat(fr, s, cur);
            if (running) begin
                m_dm[m_half][s * NCH + cur] = pat(fr, s, cur);
                m_dv[m_half][s * NCH + cur] = 1;
            end
        end
        if (running) begin
            e_chan = 5'(cur);
            m_next = (cur + 1) % NCH;
            m_run = 1;
        end
        frame_sync = pulse;
        if (wq_rd < wq_n) begin
            reg_wr = 1; reg_sel = wq_sel[wq_rd]; reg_addr = wq_addr[wq_rd]; reg_wdata = wq_dat[wq_rd];
            unique case (wq_sel[wq_rd])
                2'd0: m_plo[wq_addr[wq_rd]] = wq_dat[wq_rd];
                2'd1: m_phi[wq_addr[wq_rd]] = wq_dat[wq_rd];
                2'd2: m_pctl = wq_dat[wq_rd];
                default: ;
            endcase
            wq_rd++;
        end else begin
            reg_wr = 0; reg_sel = 2'd3;
        end
        e_have = 1;
    endtask

    task automatic run_frame(input bit pulse0, input int nslots, input bit ok);
        for (int c = 0; c < nslots; c++) slot(pulse0 && c == 0, ok);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < NENT; i++) begin
            m_plo[i] = 0; m_phi[i] = 0; m_alo[i] = 0; m_ahi[i] = 0;
            m_dv[0][i] = 0; m_dv[1][i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1 oe", 32'(tx_oe), 32'h0);
        chk("R1 strobe", 32'(tx_strobe), 32'h0);
        chk("R1 data", 32'(tx_data[31:0]), 32'h0);
        chk("R1 chan", 32'(tx_chan), 32'h0);
        // R1: hunting with traffic on the inputs
        repeat (6) slot(0, 1);

        // map A: variable delay, enabled, junk high bits on some entries (R3 R8 R11)
        for (int i = 0; i < NENT; i++) begin
            push(2'd0, 8'(i), 8'(i * 29 + 11));
            push(2'd1, 8'(i), 8'h01 | ((i % 2) != 0 ? 8'h02 : 8'h00) | ((i % 5) == 0 ? 8'hB8 : 8'h00));
        end
        for (int f = 0; f < 19; f++) run_frame((f % 3) != 1, NCH, 1);

        // map B: constant delay, messages, disabled channels, global disable (R4 R6 R9 R10)
        for (int i = 0; i < NENT; i++) begin
            push(2'd0, 8'(i), 8'(i * 53 + 3));
            push(2'd1, 8'(i), ((i % 7) != 0 ? 8'h01 : 8'h00) | (((i / 2) % 2) != 0 ? 8'h02 : 8'h00)
                              | ((i % 2) != 0 ? 8'h40 : 8'h00) | ((i % 3) == 0 ? 8'h04 : 8'h00));
        end
        for (int f = 0; f < 19; f++) run_frame(f != 8, NCH, !(f == 5 || f == 6));

        // R2: shortened frame re-aligned by a pulse, then a wrap
        run_frame(1, 10, 1);
        run_frame(1, NCH, 1);
        run_frame(0, NCH, 1);

        // R5: forced messages, then R11: other control bits ignored
        push(2'd2, 8'h00, 8'h40);
        push(2'd3, 8'h00, 8'hFF);
        for (int f = 0; f < 3; f++) run_frame(1, NCH, 1);
        push(2'd2, 8'h00, 8'hBF);
        for (int f = 0; f < 3; f++) run_frame(1, NCH, 1);
        slot(0, 1);
        summary();
    end

endmodule